// File: doc/BRIEF.md
# Dual-Counter Oscillator Frequency Meter

This block compares the rate of an internal oscillator with a reference clock. One of three oscillator inputs is picked by a source register. The fast radio-frequency oscillator first passes through a divide-by-256 stage. Each input and the reference are brought into the system clock domain, where their rising edges are detected. Counter 1 counts the measured edges. Counter 2 counts the reference edges after a fixed divide-by-2 prescaler and closes the measurement window once it reaches a programmed count.

Software enables a run, waits for the one-cycle done pulse, then reads the frozen counts through a byte-wide read port. Frequency arithmetic happens elsewhere. A swap bit exchanges the two clock paths. A preset bit forces both counters to all ones, a clear bit holds counter 1 at zero, and a route bit copies the selected source level to an output pin.

The window control is a three-state machine. ST_IDLE holds the counters. ST_RUN counts. ST_DONE freezes the counters after the window closes. The transitions are:
- ST_IDLE to ST_RUN on a rising enable bit (start).
- ST_RUN to ST_DONE when counter 2 reaches its limit (window hit).
- ST_RUN or ST_DONE to ST_IDLE when enable falls.
- Any state to ST_IDLE while preset is set.

Top module: `osc_freq_meter`

## Requirements
- R1: After reset, both counters read 0, rd_lo and rd_hi are 0, cnt_done is 0 and meas_out is 0.
- R2: The source register (written by wr_src) selects the measured input by priority. Bit 0 (IF input) has highest priority, then bit 1 (RF input), then bit 2 (stereo-decoder input). With none of these bits set, the measured path stays idle and counter 1 does not change.
- R3: The RF input advances the measured path once per 256 rising edges. The divider restarts at each start.
- R4: Control bits [6:4] hold code n, and the window limit is 2·4^n reference-side counts. Counter 2 advances once per two reference edges, with the prescaler restarted at start. When counter 2 reaches the limit, the run stops and both counters stop changing.
- R5: cnt_done is high for exactly one cycle each time a window closes.
- R6: After the window closes, counter 1 keeps its value while further measured edges arrive, until clear, preset or a new start.
- R7: While control bit 0 is 1, both counters read 0xFFFF and ignore edges and enable. After the bit is released with enable low, they keep 0xFFFF.
- R8: While control bit 7 is 1, counter 1 reads 0 and counter 2 still counts. Releasing the bit with enable held does not restart the run.
- R9: A 0-to-1 change of control bit 2 zeroes both counters and starts a run. Clearing bit 2 holds the counts. Control writes that keep bit 2 at 1 do not restart the run.
- R10: With control bit 3 at 1, the reference edges drive counter 1 with no prescaler, and the selected source drives counter 2 through the divide-by-2 prescaler.
- R11: Control bit 1 selects counter 2 (1) or counter 1 (0) for readback. rd_lo shows the live low byte. A pulse on rd_lo_strobe captures the high byte into rd_hi, visible from the next cycle, and rd_hi holds that value until the next strobe.
- R12: When source bit 4 is 1, meas_out follows the synchronized level of the selected input. Otherwise meas_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_ctrl | input | 1 | Load control register from wdata |
| wr_src | input | 1 | Load source register from wdata bits 4, 2..0 |
| wdata | input | 8 | Write data |
| rd_lo_strobe | input | 1 | Low-byte read; captures high byte |
| src_if | input | 1 | IF oscillator input |
| src_fm | input | 1 | RF oscillator input (divided by 256) |
| src_sd | input | 1 | Stereo-decoder oscillator input |
| ref_in | input | 1 | Reference clock input |
| rd_lo | output | 8 | Low byte of selected counter |
| rd_hi | output | 8 | Captured high byte |
| cnt_done | output | 1 | One-cycle window-closed pulse |
| meas_out | output | 1 | Routed source level |

## Verification
A wrong window state shows at the ports within one reference-side count. A machine stuck in ST_RUN keeps counter 2 moving past its limit and never pulses cnt_done. An early ST_DONE freezes counter 1 short of the number of measured edges driven. A divider or prescaler phase that is not restarted at start shifts the readback by one count, which is visible on the first readback after the expected edges. A lost shadow capture leaves rd_hi stale on the cycle after the strobe.

// File: rtl/osc_meter_pkg.sv
package osc_meter_pkg;

    localparam int CNT_W  = 16;
    localparam int CODE_W = 3;

    // control register bit positions
    localparam int CB_PRESET = 0;
    localparam int CB_RDSEL  = 1;
    localparam int CB_EN     = 2;
    localparam int CB_SWAP   = 3;
    localparam int CB_CODE   = 4;
    localparam int CB_CLEAR  = 7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } win_state_t;

    function automatic logic [CNT_W:0] win_limit(input logic [CODE_W-1:0] code);
        logic [CNT_W:0] v;
        v = (CNT_W+1)'(2) << (2 * int'(code));
        return v;
    endfunction

endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise
);
    logic s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= din;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign lvl  = s2;
    assign rise = s2 & ~s3;
endmodule

// File: rtl/osc_pulse_div.sv
module osc_pulse_div #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic pin,
    output logic pout
);
    localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (pin)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    assign pout = pin & ~clr & (cnt == LAST);
endmodule

// File: rtl/osc_window_ctl.sv
module osc_window_ctl
    import osc_meter_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_en,
    input  logic              ctrl_preset,
    input  logic              ctrl_clear,
    input  logic [CODE_W-1:0] win_code,
    input  logic              p1,
    input  logic              p2,
    output logic              start_o,
    output logic [CNT_W-1:0]  c1,
    output logic [CNT_W-1:0]  c2,
    output logic              done_o
);
    win_state_t st, st_nx;
    logic       en_prev;
    logic       hit;
    logic [CNT_W:0] lim;

    assign lim     = win_limit(win_code);
    assign start_o = ctrl_en & ~en_prev & ~ctrl_preset;
    assign hit     = (st == ST_RUN) & p2 & (({1'b0, c2} + 1'b1) == lim);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            en_prev <= 1'b0;
        end else begin
            st      <= st_nx;
            en_prev <= ctrl_en;
        end
    end

    // next state
    always_comb begin
        st_nx = st;
        if (ctrl_preset) begin
            st_nx = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: if (start_o) st_nx = ST_RUN;
                ST_RUN: begin
                    if (!ctrl_en)  st_nx = ST_IDLE;
                    else if (hit)  st_nx = ST_DONE;
                end
                ST_DONE: if (!ctrl_en) st_nx = ST_IDLE;
                default: st_nx = ST_IDLE;
            endcase
        end
    end

    // outputs: counters and done pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c1     <= '0;
            c2     <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= hit & ~ctrl_preset;
            if (ctrl_preset)
                c1 <= '1;
            else if (ctrl_clear || start_o)
                c1 <= '0;
            else if (st == ST_RUN && p1)
                c1 <= c1 + 1'b1;

            if (ctrl_preset)
                c2 <= '1;
            else if (start_o)
                c2 <= '0;
            else if (st == ST_RUN && p2)
                c2 <= c2 + 1'b1;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R5
    AST_C1_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && !ctrl_preset && !ctrl_clear && !start_o) |=> $stable(c1)); // R6
    AST_PRESET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_preset |=> (c1 == '1 && c2 == '1)); // R7
    AST_CLEAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_clear && !ctrl_preset) |=> (c1 == '0)); // R8
    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (c2 == '0 && st == ST_RUN)); // R9
endmodule

// File: rtl/osc_freq_meter.sv
module osc_freq_meter
    import osc_meter_pkg::*;
#(
    parameter int FM_DIV  = 256,
    parameter int REF_PRE = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl,
    input  logic       wr_src,
    input  logic [7:0] wdata,
    input  logic       rd_lo_strobe,
    input  logic       src_if,
    input  logic       src_fm,
    input  logic       src_sd,
    input  logic       ref_in,
    output logic [7:0] rd_lo,
    output logic [7:0] rd_hi,
    output logic       cnt_done,
    output logic       meas_out
);
    localparam int NIN    = 4;
    localparam int BYTE_W = 8;

    logic [7:0]     ctrl_q;
    logic [3:0]     src_q;     // {route, sd, fm, if}
    logic [NIN-1:0] raw, lvl, rise;
    logic           fm_p, sel_p, sel_lvl, p1, pre_in, p2, start;
    logic [CNT_W-1:0] c1, c2, cur;
    logic [BYTE_W-1:0] shadow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            src_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata;
            if (wr_src)  src_q  <= {wdata[4], wdata[2:0]};
        end
    end

    assign raw = {ref_in, src_sd, src_fm, src_if};

    for (genvar i = 0; i < NIN; i++) begin : g_sync
        osc_edge_sync u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw[i]),
            .lvl  (lvl[i]),
            .rise (rise[i])
        );
    end

    osc_pulse_div #(.DIV(FM_DIV)) u_fmdiv (
        .clk(clk), .rst_n(rst_n), .clr(start), .pin(rise[1]), .pout(fm_p)
    );

    always_comb begin
        if (src_q[0]) begin
            sel_p = rise[0]; sel_lvl = lvl[0];
        end else if (src_q[1]) begin
            sel_p = fm_p;    sel_lvl = lvl[1];
        end else if (src_q[2]) begin
            sel_p = rise[2]; sel_lvl = lvl[2];
        end else begin
            sel_p = 1'b0;    sel_lvl = 1'b0;
        end
    end

    assign meas_out = src_q[3] & sel_lvl;

    assign p1     = ctrl_q[CB_SWAP] ? rise[3] : sel_p;
    assign pre_in = ctrl_q[CB_SWAP] ? sel_p   : rise[3];

    osc_pulse_div #(.DIV(REF_PRE)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(start), .pin(pre_in), .pout(p2)
    );

    osc_window_ctl u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_en    (ctrl_q[CB_EN]),
        .ctrl_preset(ctrl_q[CB_PRESET]),
        .ctrl_clear (ctrl_q[CB_CLEAR]),
        .win_code   (ctrl_q[CB_CODE +: CODE_W]),
        .p1         (p1),
        .p2         (p2),
        .start_o    (start),
        .c1         (c1),
        .c2         (c2),
        .done_o     (cnt_done)
    );

    assign cur   = ctrl_q[CB_RDSEL] ? c2 : c1;
    assign rd_lo = cur[BYTE_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shadow <= '0;
        else if (rd_lo_strobe)
            shadow <= cur[CNT_W-1 -: BYTE_W];
    end

    assign rd_hi = shadow;

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_lo_strobe |=> $stable(rd_hi)); // R11
    AST_NO_SRC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q[2:0] == 3'b000 && !ctrl_q[CB_SWAP]) |-> !p1); // R2
endmodule

// File: tb/sim_osc_freq_meter.sv
module sim_osc_freq_meter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_ctrl = 1'b0, wr_src = 1'b0, rd_lo_strobe = 1'b0;
    logic [7:0] wdata = '0;
    logic src_if = 0, src_fm = 0, src_sd = 0, ref_in = 0;
    logic [7:0] rd_lo, rd_hi;
    logic cnt_done, meas_out;

    int total = 0, bad = 0;
    int done_cnt = 0;
    int done_long = 0;
    logic done_prev = 1'b0;

    always #10 clk = ~clk;

    osc_freq_meter u0 (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_src(wr_src),
        .wdata(wdata), .rd_lo_strobe(rd_lo_strobe), .src_if(src_if),
        .src_fm(src_fm), .src_sd(src_sd), .ref_in(ref_in),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .cnt_done(cnt_done), .meas_out(meas_out)
    );

    always @(negedge clk) begin
        if (cnt_done) done_cnt++;
        if (cnt_done && done_prev) done_long++;
        done_prev = cnt_done;
    end

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic is_ctrl, input logic [7:0] v);
        @(negedge clk);
        wdata = v;
        if (is_ctrl) wr_ctrl = 1'b1; else wr_src = 1'b1;
        @(negedge clk);
        wr_ctrl = 1'b0; wr_src = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic edges(input int which, input int n);
        for (int k = 0; k < n; k++) begin
            case (which)
                0: src_if = 1'b1; 1: src_fm = 1'b1;
                2: src_sd = 1'b1; default: ref_in = 1'b1;
            endcase
            repeat (4) @(negedge clk);
            case (which)
                0: src_if = 1'b0; 1: src_fm = 1'b0;
                2: src_sd = 1'b0; default: ref_in = 1'b0;
            endcase
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic rd16(output int v);
        @(negedge clk);
        rd_lo_strobe = 1'b1;
        @(negedge clk);
        rd_lo_strobe = 1'b0;
        v = {rd_hi, rd_lo};
    endtask

    task automatic t_reset;
        int v;
        rd16(v);
        chk("R1 c1", v, 0);
        chk("R1 done/pin", {cnt_done, meas_out}, 0);
    endtask

    task automatic t_window_basic;
        int v, d0;
        d0 = done_cnt;
        wr(0, 8'h01); wr(1, 8'h00); wr(1, 8'h04);
        edges(0, 5); edges(3, 3);
        wr(1, 8'h06); rd16(v);
        chk("R4 c2 after 3 ref", v, 1);
        chk("R4 no early done", done_cnt - d0, 0);
        edges(3, 1);
        chk("R5 one done pulse", done_cnt - d0, 1);
        chk("R5 pulse width", done_long, 0);
        edges(0, 4);
        wr(1, 8'h04); rd16(v);
        chk("R6 c1 frozen", v, 5);
    endtask

    task automatic t_fm_div;
        int v, d0;
        d0 = done_cnt;
        wr(0, 8'h02); wr(1, 8'h00); wr(1, 8'h14);
        edges(1, 255); rd16(v);
        chk("R3 255 rf edges", v, 0);
        edges(1, 1); rd16(v);
        chk("R3 256 rf edges", v, 1);
        edges(1, 344); edges(3, 16); rd16(v);
        chk("R3 600 rf edges", v, 2);
        wr(1, 8'h16); rd16(v);
        chk("R4 code1 limit 8", v, 8);
        chk("R4 code1 done", done_cnt - d0, 1);
    endtask

    task automatic t_priority;
        int v;
        wr(0, 8'h06); wr(1, 8'h00); wr(1, 8'h04);
        edges(2, 3); rd16(v);
        chk("R2 rf beats sd", v, 0);
        wr(0, 8'h04); edges(2, 3); rd16(v);
        chk("R2 sd counted", v, 3);
        wr(0, 8'h00); edges(2, 2); edges(0, 2); rd16(v);
        chk("R2 no source", v, 3);
    endtask

    task automatic t_code2;
        int v, d0;
        d0 = done_cnt;
        wr(0, 8'h01); wr(1, 8'h00); wr(1, 8'h26);
        edges(3, 62); rd16(v);
        chk("R4 code2 at 31", v, 31);
        chk("R4 code2 not done", done_cnt - d0, 0);
        edges(3, 2);
        chk("R4 code2 done", done_cnt - d0, 1);
        edges(3, 4); rd16(v);
        chk("R4 c2 stops at 32", v, 32);
    endtask

    task automatic t_swap;
        int v, d0;
        d0 = done_cnt;
        wr(0, 8'h01); wr(1, 8'h00); wr(1, 8'h0C);
        edges(3, 3); rd16(v);
        chk("R10 ref drives c1", v, 3);
        edges(0, 4);
        wr(1, 8'h0E); rd16(v);
        chk("R10 src drives c2 /2", v, 2);
        chk("R10 done", done_cnt - d0, 1);
    endtask

    task automatic t_preset;
        int v;
        wr(1, 8'h00); wr(1, 8'h05);
        edges(3, 3); edges(0, 3); rd16(v);
        chk("R7 c1 preset", v, 16'hFFFF);
        wr(1, 8'h07); rd16(v);
        chk("R7 c2 preset", v, 16'hFFFF);
        wr(1, 8'h02); edges(3, 2); rd16(v);
        chk("R7 c2 kept after release", v, 16'hFFFF);
    endtask

    task automatic t_clear;
        int v;
        wr(0, 8'h01); wr(1, 8'h00); wr(1, 8'h84);
        edges(0, 3); rd16(v);
        chk("R8 c1 held 0", v, 0);
        edges(3, 2); wr(1, 8'h86); rd16(v);
        chk("R8 c2 counts", v, 1);
        wr(1, 8'h04); edges(0, 2); rd16(v);
        chk("R8 release no restart", v, 2);
    endtask

    task automatic t_enable;
        int v;
        wr(0, 8'h01); wr(1, 8'h00); wr(1, 8'h04);
        edges(0, 3); wr(1, 8'h00); edges(0, 2); rd16(v);
        chk("R9 hold when disabled", v, 3);
        wr(1, 8'h04); rd16(v);
        chk("R9 restart zeroes", v, 0);
    endtask

    task automatic t_pin;
        wr(0, 8'h11);
        src_if = 1'b1; repeat (4) @(negedge clk);
        chk("R12 routed high", meas_out, 1);
        src_if = 1'b0; repeat (4) @(negedge clk);
        chk("R12 routed low", meas_out, 0);
        wr(0, 8'h01);
        src_if = 1'b1; repeat (4) @(negedge clk);
        chk("R12 not routed", meas_out, 0);
        src_if = 1'b0; repeat (4) @(negedge clk);
    endtask

    task automatic t_shadow;
        int v;
        wr(0, 8'h01); wr(1, 8'h00); wr(1, 8'h04);
        edges(0, 255); rd16(v);
        chk("R11 read 255", v, 255);
        edges(0, 2);
        repeat (2) @(negedge clk);
        chk("R11 hi stale w/o strobe", {rd_hi, rd_lo}, 16'h0001);
        rd16(v);
        chk("R11 hi after strobe", v, 257);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_window_basic();
        t_fm_div();
        t_priority();
        t_code2();
        t_swap();
        t_preset();
        t_clear();
        t_enable();
        t_pin();
        t_shadow();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule